// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Controller

This block watches the live signals of one removable-card socket and turns their changes into host interrupts. It samples card-detect, battery-voltage-detect, ready/busy, write-protect, wait and power-good through a two-flop synchronizer. Each change of a monitored signal sets a sticky event flag, and a single-cycle access-timeout pulse from outside sets one more. Each flag is gated by its own enable bit. The OR of the enabled pending flags is the status-change summary, which is steered to one of two host interrupt lines. The card's own I/O interrupt request has a separate enable and separate line steering, and it acts only when the socket runs in memory-plus-I/O mode.

Software sees three 16-bit registers on a simple register bus. The control word holds the enables, the steering bits and the interface mode. The diagnostic word can replace most card pins with register bits so that event logic can be tested without a card. The status word shows live levels in its low byte and sticky events in its high byte. Software clears an event by writing 1 to its bit. The read data is registered and appears one cycle after the select. Both interrupt outputs are registered.

Top module: `sock_evt_ctrl`

## Requirements
- R1: After a synchronous reset the control, diagnostic and event state are zero. Both host_irq_o lines are 0, and reg_rdata_o is 0 until the first read.
- R2: In memory-only mode (control bit0 = 0), status bits 7..0 show the synchronized pins {card_pins_i[7:0]}. The bit order is bit7 card-detect 2, bit6 card-detect 1, bit5 BVD2, bit4 BVD1, bit3 ready, bit2 write-protect, bit1 wait, bit0 power-good.
- R3: In I/O mode (control bit0 = 1), status bits 5..2 show card_pins_i[11:8] (speaker, status-change, I/O request, 16-bit-I/O) and status bit15 shows the synchronized card interrupt card_pins_i[12]. In memory-only mode bit15 reads 0.
- R4: Any change of a synchronized signal sets a sticky event bit whether or not its enable is set. A change of either card-detect sets bit13, BVD2 sets bit12, BVD1 sets bit11, ready sets bit10 and write-protect sets bit9. A tmo_pulse_i cycle sets bit8. Wait and power-good set no event.
- R5: Writing the status word clears each event bit 13..8 written as 1 and keeps those written as 0. A set in the same cycle wins over the clear. Bits 15, 14 and 7..0 of the write have no effect.
- R6: Status bit14 is 1 while any event bit is pending with its enable set. The enables are control bits 11 (card-detect), 10 (BVD2), 9 (BVD1), 8 (ready), 7 (write-protect) and 6 (timeout).
- R7: While bit14 is set, host_irq_o[control bit12] is driven to 1 one cycle later. Line 0 is used when bit12 is 0 and line 1 when it is 1.
- R8: When control bit0 and bit4 are both 1 and the synchronized card interrupt is high, host_irq_o[control bit3] is 1. Otherwise the card interrupt drives no line.
- R9: When diagnostic bit8 is 1, diagnostic bits 14, 13, 12, 11, 10 and 9 replace card-detect 1, BVD2, BVD1, ready, write-protect and wait for both the live status and change detection, and those pins are ignored.
- R10: reg_sel_i selects 0 control, 1 diagnostic, 2 status and 3 a zero word. Only control bits 12..6, 4, 3 and 0 and diagnostic bits 14..8 can be written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_sel_i | input | 2 | Register select: 0 control, 1 diagnostic, 2 status |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data of the select from the previous cycle |
| card_pins_i | input | 13 | Asynchronous card signals, bit order as in R2, R3 |
| tmo_pulse_i | input | 1 | Synchronous single-cycle access-timeout event |
| host_irq_o | output | 2 | Host interrupt lines 0 and 1 |

## Verification
The bench writes a clear of an event bit in the same cycle as a new timeout pulse. A design that lets the clear win would silently lose that event. It holds events that are masked and then enables them, which catches a design that drops events instead of latching them. It toggles pins while diagnostic mode is on, which exposes a design that still reads the real pins. It also flips the interface mode with the card interrupt high, which catches a bit15 or an I/O interrupt that leaks out in memory-only mode.

// File: rtl/sock_evt_pkg.sv
package sock_evt_pkg;
  localparam int DATA_W   = 16;
  localparam int NUM_PINS = 13;
  localparam int NUM_EVT  = 6;
  localparam int NUM_LINES = 2;

  // card pin positions
  localparam int P_PWR  = 0;
  localparam int P_WAIT = 1;
  localparam int P_WP   = 2;
  localparam int P_RDY  = 3;
  localparam int P_BVD1 = 4;
  localparam int P_BVD2 = 5;
  localparam int P_CD1  = 6;
  localparam int P_CD2  = 7;
  localparam int P_IRQ  = 12;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIAG = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h1FD9;
  localparam logic [DATA_W-1:0] DIAG_WMASK = 16'h7F00;
endpackage

// File: rtl/sock_sync.sv
module sock_sync #(
  parameter int WIDTH  = 13,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sock_evt_latch.sv
module sock_evt_latch #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] evt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) evt_q <= '0;
    else       evt_q <= (evt_q & ~clr_i) | set_i;
  end

  assign evt_o = evt_q;

  // R4: a set always lands, even with a simultaneous clear
  a_r4_set_lands: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_i != '0) |=> ((evt_q & $past(set_i)) == $past(set_i)));

  // R4: a pending flag stays until cleared
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_q != '0) |=> ((~evt_q & $past(evt_q & ~clr_i)) == '0));

  // R5: a clear with no concurrent set empties the flag
  a_r5_w1c: assert property (@(posedge clk_i) disable iff (rst_i)
    ((clr_i & ~set_i) != '0) |=> ((evt_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/sock_irq_route.sv
module sock_irq_route #(
  parameter int LINES = 2,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sc_act_i,
  input  logic [SEL_W-1:0] sc_sel_i,
  input  logic             io_act_i,
  input  logic [SEL_W-1:0] io_sel_i,
  output logic [LINES-1:0] irq_o
);
  logic [LINES-1:0] irq_q;
  logic [LINES-1:0] irq_d;

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      irq_d[l] = (sc_act_i && (sc_sel_i == SEL_W'(l))) ||
                 (io_act_i && (io_sel_i == SEL_W'(l)));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= '0;
    else       irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R1: reset clears both lines
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (irq_q == '0));

  // R7: summary reaches the chosen line next cycle
  a_r7_sc_line: assert property (@(posedge clk_i) disable iff (rst_i)
    sc_act_i |=> irq_q[$past(sc_sel_i)]);

  // R8: card interrupt reaches its chosen line next cycle
  a_r8_io_line: assert property (@(posedge clk_i) disable iff (rst_i)
    io_act_i |=> irq_q[$past(io_sel_i)]);

  // R7, R8: with no source active every line drops
  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sc_act_i && !io_act_i) |=> (irq_q == '0));
endmodule

// File: rtl/sock_evt_ctrl.sv
module sock_evt_ctrl
  import sock_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_PINS-1:0] card_pins_i,
  input  logic              tmo_pulse_i,
  output logic [NUM_LINES-1:0] host_irq_o
);
  logic [DATA_W-1:0]   ctrl_q, diag_q, rdata_q;
  logic [NUM_PINS-1:0] pins_s;
  logic [7:0]          eff, prev_q, chg, live;
  logic [NUM_EVT-1:0]  evt_set, evt_clr, evt_q;
  logic                diag_en, io_mode, sc_act, io_act;
  logic [DATA_W-1:0]   stat_w;
  reg_sel_e            sel;

  assign sel = reg_sel_e'(reg_sel_i);

  sock_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(card_pins_i), .q_o(pins_s));

  // register writes
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
      diag_q <= '0;
    end else if (reg_wr_i) begin
      if (sel == SEL_CTRL) ctrl_q <= reg_wdata_i & CTRL_WMASK;
      if (sel == SEL_DIAG) diag_q <= reg_wdata_i & DIAG_WMASK;
    end
  end

  assign diag_en = diag_q[8];
  assign io_mode = ctrl_q[0];

  // effective memory-view signals, diagnostic override
  always_comb begin
    eff         = pins_s[7:0];
    if (diag_en) begin
      eff[P_CD1]  = diag_q[14];
      eff[P_BVD2] = diag_q[13];
      eff[P_BVD1] = diag_q[12];
      eff[P_RDY]  = diag_q[11];
      eff[P_WP]   = diag_q[10];
      eff[P_WAIT] = diag_q[9];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= eff;
  end

  assign chg = eff ^ prev_q;

  // event order: 0 timeout, 1 wp, 2 ready, 3 bvd1, 4 bvd2, 5 card-detect
  assign evt_set = {chg[P_CD1] | chg[P_CD2], chg[P_BVD2], chg[P_BVD1],
                    chg[P_RDY], chg[P_WP], tmo_pulse_i};
  assign evt_clr = (reg_wr_i && sel == SEL_STAT) ? reg_wdata_i[13:8] : '0;

  sock_evt_latch #(.N(NUM_EVT)) u_latch (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(evt_set), .clr_i(evt_clr),
    .evt_o(evt_q));

  assign sc_act = |(evt_q & ctrl_q[11:6]);
  assign io_act = io_mode & ctrl_q[4] & pins_s[P_IRQ];

  sock_irq_route #(.LINES(NUM_LINES)) u_route (
    .clk_i(clk_i), .rst_i(rst_i),
    .sc_act_i(sc_act), .sc_sel_i(ctrl_q[12]),
    .io_act_i(io_act), .io_sel_i(ctrl_q[3]),
    .irq_o(host_irq_o));

  assign live   = io_mode ? {eff[7:6], pins_s[11:8], eff[1:0]} : eff;
  assign stat_w = {io_mode & pins_s[P_IRQ], sc_act, evt_q, live};

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else begin
      case (sel)
        SEL_CTRL: rdata_q <= ctrl_q;
        SEL_DIAG: rdata_q <= diag_q;
        SEL_STAT: rdata_q <= stat_w;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;

  // R3: memory-only mode never reports a card interrupt in bit15
  a_r3_mem_no_bit15: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel == SEL_STAT && !ctrl_q[0]) |=> !reg_rdata_o[15]);

  // R10: reserved control bits never read back set
  a_r10_ctrl_rsvd: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel == SEL_CTRL) |=> ((reg_rdata_o & ~CTRL_WMASK) == '0));
endmodule

// File: tb/sock_evt_ctrl_tb_top.sv
module sock_evt_ctrl_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  sel = 0;
  logic        wr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [12:0] pins = 0;
  logic        tmo = 0;
  logic [1:0]  irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sock_evt_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .reg_sel_i(sel), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .card_pins_i(pins),
    .tmo_pulse_i(tmo), .host_irq_o(irq));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] s, logic [15:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] s, output logic [15:0] v);
    @(negedge clk); sel = s; wr = 0;
    @(posedge clk); @(negedge clk); v = rdata;
  endtask

  task automatic set_pins(logic [12:0] p);
    @(negedge clk); pins = p;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_all();
    wr_reg(2, 16'h3F00);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 irq", {14'h0, irq}, 16'h0);
    rd_reg(0, v); chk("R1 ctrl", v, 16'h0);
    rd_reg(1, v); chk("R1 diag", v, 16'h0);
    rd_reg(2, v); chk("R1 status", v, 16'h0);
  endtask

  task automatic t_live();
    logic [15:0] v;
    set_pins(13'h0A5);
    rd_reg(2, v); chk("R2 R4 mem live+events", v, 16'h32A5);
    wr_reg(0, 16'h0001);
    set_pins(13'h0AA5);
    rd_reg(2, v); chk("R3 io live", v, 16'h32A9);
    set_pins(13'h1AA5);
    rd_reg(2, v); chk("R3 io bit15", v, 16'hB2A9);
    wr_reg(0, 16'h0000);
    rd_reg(2, v); chk("R3 mem bit15 zero", v, 16'h32A5);
    set_pins(13'h0);
    clear_all();
    rd_reg(2, v); chk("R4 wait/pwr no event", v, 16'h0);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    set_pins(13'h00C);
    rd_reg(2, v); chk("R4 wp+rdy events", v, 16'h060C);
    wr_reg(2, 16'h0200);
    rd_reg(2, v); chk("R5 clear one", v, 16'h040C);
    wr_reg(2, 16'hC0FF);
    rd_reg(2, v); chk("R5 other bits ignored", v, 16'h040C);
    wr_reg(2, 16'h0400);
    rd_reg(2, v); chk("R5 clear rest", v, 16'h000C);
    @(negedge clk); tmo = 1;
    @(negedge clk); tmo = 0;
    rd_reg(2, v); chk("R4 timeout event", v, 16'h010C);
    @(negedge clk); sel = 2; wdata = 16'h0100; wr = 1; tmo = 1;
    @(negedge clk); wr = 0; tmo = 0;
    rd_reg(2, v); chk("R5 set wins over clear", v, 16'h010C);
    set_pins(13'h0);
    clear_all();
  endtask

  task automatic t_summary();
    logic [15:0] v;
    set_pins(13'h008);
    repeat (2) @(negedge clk);
    chk("R6 masked no irq", {14'h0, irq}, 16'h0);
    wr_reg(0, 16'h0080);
    rd_reg(2, v); chk("R6 wrong enable no summary", v & 16'h4000, 16'h0);
    wr_reg(0, 16'h0100);
    rd_reg(2, v); chk("R6 summary set", v & 16'h4000, 16'h4000);
    @(negedge clk); chk("R7 line0", {14'h0, irq}, 16'h1);
    wr_reg(0, 16'h1100);
    @(negedge clk); chk("R7 line1", {14'h0, irq}, 16'h2);
    clear_all();
    chk("R7 drops after clear", {14'h0, irq}, 16'h0);
    set_pins(13'h0);
    clear_all();
    wr_reg(0, 16'h0000);
  endtask

  task automatic t_io_irq();
    logic [15:0] v;
    wr_reg(0, 16'h0011);
    set_pins(13'h1000);
    chk("R8 io line0", {14'h0, irq}, 16'h1);
    wr_reg(0, 16'h0019);
    @(negedge clk); chk("R8 io line1", {14'h0, irq}, 16'h2);
    wr_reg(0, 16'h0009);
    @(negedge clk); chk("R8 disabled", {14'h0, irq}, 16'h0);
    wr_reg(0, 16'h0018);
    @(negedge clk); chk("R8 mem mode no irq", {14'h0, irq}, 16'h0);
    rd_reg(2, v); chk("R3 mem mode bit15", v, 16'h0);
    set_pins(13'h0);
    wr_reg(0, 16'h0000);
    clear_all();
  endtask

  task automatic t_diag();
    logic [15:0] v;
    wr_reg(1, 16'h0100);
    rd_reg(2, v); chk("R9 enable alone quiet", v, 16'h0);
    wr_reg(1, 16'h4100);
    rd_reg(2, v); chk("R9 diag cd1", v, 16'h2040);
    wr_reg(1, 16'h0100);
    clear_all();
    set_pins(13'h040);
    rd_reg(2, v); chk("R9 pin ignored", v, 16'h0);
    wr_reg(1, 16'h3F00);
    rd_reg(2, v); chk("R9 diag fields", v, 16'h1E3E);
    wr_reg(1, 16'h0000);
    clear_all();
    rd_reg(2, v); chk("R9 pins back", v, 16'h0040);
    set_pins(13'h0);
    clear_all();
  endtask

  task automatic t_readback();
    logic [15:0] v;
    wr_reg(0, 16'hFFFF);
    rd_reg(0, v); chk("R10 ctrl mask", v, 16'h1FD9);
    wr_reg(1, 16'hFFFF);
    rd_reg(1, v); chk("R10 diag mask", v, 16'h7F00);
    rd_reg(3, v); chk("R10 sel3 zero", v, 16'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_live();
    t_w1c();
    t_summary();
    t_io_irq();
    t_diag();
    t_readback();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule